// File: doc/BRIEF.md
# Cascaded Integer Clock-Enable Divider

This block turns one fast clock into two slower clock-enable strobes. A first divider stage counts fast-clock cycles and emits a one-cycle peripheral-rate enable every (P+1) cycles. A second stage counts only those peripheral enables and emits a slow-rate enable every (S+1) of them. The fast logic that consumes the strobes qualifies its registers with them instead of running on separately generated clocks.

Both divide values live in one 32-bit control word that software writes and reads back. The hardware only reads the fields. A sleep-exit event input marks the return from deep sleep. The control word keeps its value across that event, but both division counters restart from zero. A field change made while a stage is counting is picked up only when that stage wraps, or when a sleep-exit event restarts it. This means no divided period is ever cut short or stretched by a write.

Top module: `cascade_clk_divider`

## Requirements
- R1: With peripheral field P (control bits 31:24), `peri_en` is high for exactly one cycle in every P+1 fast-clock cycles. P=0 keeps it high every cycle.
- R2: With slow field S (control bits 15:8), `slow_en` rises once in every S+1 peripheral enables, so its period is (P+1)*(S+1) cycles. `slow_en` is never high unless `peri_en` is high in the same cycle.
- R3: A write (`cfg_we` high) stores `cfg_wdata[31:24]` as P and `cfg_wdata[15:8]` as S. From the next cycle, `cfg_rdata` shows P in bits 31:24 and S in bits 15:8. Bits 23:16 and 7:0 always read zero.
- R4: During and right after reset, the control word reads 0x00000000 and both enables are high every cycle (divide by 1 in both stages).
- R5: In a cycle with `wake_evt` high, both enables are low. Both counters are then zero, and each stage adopts the current field value. The first `peri_en` after the event comes P+1 cycles after the event cycle, and the first `slow_en` comes (P+1)*(S+1) cycles after it.
- R6: A field value written while a stage is mid-count does not change the period in progress. It applies from the stage's next wrap.
- R7: A sleep-exit event leaves the control word unchanged.
- R8: With `cfg_we` low, `cfg_wdata` has no effect on the control word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wdata | input | 32 | Control word write data |
| cfg_we | input | 1 | Control word write strobe |
| wake_evt | input | 1 | Single-cycle sleep-exit event; restarts both counters |
| peri_en | output | 1 | Peripheral-rate enable strobe |
| slow_en | output | 1 | Slow-rate enable strobe |
| cfg_rdata | output | 32 | Control word readback |

## Verification
Some properties hold in every cycle, and the bound checker watches them. It checks that a slow strobe only appears with a peripheral strobe and that the sleep-exit cycle is silent. It also checks that reserved bits read zero, and that the control word changes only through a write and then holds exactly the written fields. Divide periods, the position of the first strobe after a sleep-exit event and the deferred take-up of a new field all depend on counting over many cycles. The bench scenarios show these: a cycle-accurate model runs beside the design, and the bench measures strobe spacing directly for field pairs that include 0 and 255.

// File: rtl/cdiv_pkg.sv
`timescale 1ns/1ps
package cdiv_pkg;
   // Number of divider stages in the cascade (peripheral, slow).
   localparam int CDIV_STAGES = 2;

   // Default layout of the control word.
   localparam int CDIV_CTRL_W   = 32;
   localparam int CDIV_DIV_W    = 8;
   localparam int CDIV_PERI_LSB = 24;
   localparam int CDIV_SLOW_LSB = 8;

   // Stage 0 is the peripheral stage, stage 1 the slow stage.
   function automatic int field_lsb(input int idx, input int peri_lsb, input int slow_lsb);
      return (idx == 0) ? peri_lsb : slow_lsb;
   endfunction

   // Bits of the control word that hold a divide field.
   function automatic logic [63:0] field_mask(input int div_w, input int peri_lsb,
                                              input int slow_lsb);
      logic [63:0] one_field;
      one_field = (64'd1 << div_w) - 64'd1;
      return (one_field << peri_lsb) | (one_field << slow_lsb);
   endfunction
endpackage

// File: rtl/cdiv_ctrl_reg.sv
`timescale 1ns/1ps
module cdiv_ctrl_reg
   import cdiv_pkg::*;
#(
   parameter int CTRL_W   = CDIV_CTRL_W,
   parameter int DIV_W    = CDIV_DIV_W,
   parameter int PERI_LSB = CDIV_PERI_LSB,
   parameter int SLOW_LSB = CDIV_SLOW_LSB,
   parameter int NSTAGE   = CDIV_STAGES
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           we_i,
   input  logic [CTRL_W-1:0]              wdata_i,
   output logic [CTRL_W-1:0]              rdata_o,
   output logic [NSTAGE-1:0][DIV_W-1:0]   fld_o
);
   localparam logic [CTRL_W-1:0] FIELD_MASK =
      CTRL_W'(field_mask(DIV_W, PERI_LSB, SLOW_LSB));

   logic [NSTAGE-1:0][DIV_W-1:0] fld_q;

   // Reserved write bits are dropped on purpose.
   logic unused_rsvd_bits;
   assign unused_rsvd_bits = ^(wdata_i & ~FIELD_MASK);

   for (genvar gi = 0; gi < NSTAGE; gi++) begin : g_field
      localparam int LSB = field_lsb(gi, PERI_LSB, SLOW_LSB);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            fld_q[gi] <= '0;
         end else if (we_i) begin
            fld_q[gi] <= wdata_i[LSB +: DIV_W];
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      for (int i = 0; i < NSTAGE; i++) begin
         rdata_o[field_lsb(i, PERI_LSB, SLOW_LSB) +: DIV_W] = fld_q[i];
      end
   end

   assign fld_o = fld_q;
endmodule

// File: rtl/cdiv_stage.sv
`timescale 1ns/1ps
module cdiv_stage #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic             step_i,
   input  logic [DIV_W-1:0] lim_fld_i,
   output logic             tick_o
);
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] lim_q;
   logic             at_end;

   assign at_end = (cnt_q == lim_q);
   assign tick_o = step_i & at_end & ~restart_i;

   // The limit is sampled only at a wrap or restart, so a period in
   // progress always runs to its original length.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lim_q <= '0;
      end else if (restart_i) begin
         cnt_q <= '0;
         lim_q <= lim_fld_i;
      end else if (step_i) begin
         if (at_end) begin
            cnt_q <= '0;
            lim_q <= lim_fld_i;
         end else begin
            cnt_q <= cnt_q + DIV_W'(1);
         end
      end
   end
endmodule

// File: rtl/cascade_clk_divider.sv
`timescale 1ns/1ps
module cascade_clk_divider
   import cdiv_pkg::*;
#(
   parameter int CTRL_W   = CDIV_CTRL_W,
   parameter int DIV_W    = CDIV_DIV_W,
   parameter int PERI_LSB = CDIV_PERI_LSB,
   parameter int SLOW_LSB = CDIV_SLOW_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CTRL_W-1:0] cfg_wdata,
   input  logic              cfg_we,
   input  logic              wake_evt,
   output logic              peri_en,
   output logic              slow_en,
   output logic [CTRL_W-1:0] cfg_rdata
);
   localparam int NSTAGE = CDIV_STAGES;

   // Elaboration-time parameter checks.
   if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div_w
      $error("cascade_clk_divider: DIV_W out of range");
   end
   if (PERI_LSB + DIV_W > CTRL_W || SLOW_LSB + DIV_W > CTRL_W) begin : g_bad_fit
      $error("cascade_clk_divider: divide field exceeds control word");
   end
   if ((PERI_LSB < SLOW_LSB + DIV_W) && (SLOW_LSB < PERI_LSB + DIV_W)) begin : g_bad_overlap
      $error("cascade_clk_divider: divide fields overlap");
   end

   logic [NSTAGE-1:0][DIV_W-1:0] fld;
   logic [NSTAGE:0]              en_chain;

   cdiv_ctrl_reg #(
      .CTRL_W   (CTRL_W),
      .DIV_W    (DIV_W),
      .PERI_LSB (PERI_LSB),
      .SLOW_LSB (SLOW_LSB),
      .NSTAGE   (NSTAGE)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (cfg_we),
      .wdata_i (cfg_wdata),
      .rdata_o (cfg_rdata),
      .fld_o   (fld)
   );

   // The first stage steps on every fast cycle; each later stage steps
   // only on the strobe of the stage before it.
   assign en_chain[0] = 1'b1;

   for (genvar gs = 0; gs < NSTAGE; gs++) begin : g_stage
      cdiv_stage #(
         .DIV_W (DIV_W)
      ) u_stage (
         .clk       (clk),
         .rst_n     (rst_n),
         .restart_i (wake_evt),
         .step_i    (en_chain[gs]),
         .lim_fld_i (fld[gs]),
         .tick_o    (en_chain[gs+1])
      );
   end

   assign peri_en = en_chain[1];
   assign slow_en = en_chain[NSTAGE];
endmodule

// File: rtl/cdiv_checker.sv
`timescale 1ns/1ps
module cdiv_checker
   import cdiv_pkg::*;
#(
   parameter int CTRL_W   = CDIV_CTRL_W,
   parameter int DIV_W    = CDIV_DIV_W,
   parameter int PERI_LSB = CDIV_PERI_LSB,
   parameter int SLOW_LSB = CDIV_SLOW_LSB
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CTRL_W-1:0] cfg_wdata,
   input logic              cfg_we,
   input logic              wake_evt,
   input logic              peri_en,
   input logic              slow_en,
   input logic [CTRL_W-1:0] cfg_rdata
);
   localparam logic [CTRL_W-1:0] FMASK =
      CTRL_W'(field_mask(DIV_W, PERI_LSB, SLOW_LSB));

   // R2
   slow_within_peri_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slow_en |-> peri_en);

   // R5
   wake_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_evt |-> (!peri_en && !slow_en));

   // R3
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata & ~FMASK) == '0);

   // R3
   write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> cfg_rdata == ($past(cfg_wdata) & FMASK));

   // R8
   no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(cfg_rdata));

   // R7
   wake_keeps_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_evt && !cfg_we) |=> $stable(cfg_rdata));
endmodule

bind cascade_clk_divider cdiv_checker #(
   .CTRL_W   (CTRL_W),
   .DIV_W    (DIV_W),
   .PERI_LSB (PERI_LSB),
   .SLOW_LSB (SLOW_LSB)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_wdata (cfg_wdata),
   .cfg_we    (cfg_we),
   .wake_evt  (wake_evt),
   .peri_en   (peri_en),
   .slow_en   (slow_en),
   .cfg_rdata (cfg_rdata)
);

// File: tb/sim_cascade_clk_divider.sv
`timescale 1ns/1ps
module sim_cascade_clk_divider;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        cfg_we = 1'b0;
   logic        wake_evt = 1'b0;
   logic        peri_en;
   logic        slow_en;
   logic [31:0] cfg_rdata;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc   = 0;

   // Reference model state (index 0: peripheral stage, 1: slow stage)
   logic [7:0] m_fld [2];
   logic [7:0] m_cnt [2];
   logic [7:0] m_lim [2];

   always #2 clk = ~clk;   // 250 MHz

   cascade_clk_divider u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wdata (cfg_wdata),
      .cfg_we    (cfg_we),
      .wake_evt  (wake_evt),
      .peri_en   (peri_en),
      .slow_en   (slow_en),
      .cfg_rdata (cfg_rdata)
   );

   function automatic logic [31:0] word_of(input logic [7:0] p, input logic [7:0] s);
      return {p, 8'h00, s, 8'h00};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s cycle=%0d actual=%h expected=%h", req, cyc, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 2; i++) begin
         m_fld[i] = '0; m_cnt[i] = '0; m_lim[i] = '0;
      end
   endtask

   // One fast cycle: drive, compare against model, advance model.
   task automatic step(input bit we, input logic [31:0] wd, input bit wk);
      bit e_p;
      bit e_s;
      @(negedge clk);
      cfg_we = we; cfg_wdata = wd; wake_evt = wk;
      #1;
      e_p = (m_cnt[0] == m_lim[0]) && !wk;
      e_s = e_p && (m_cnt[1] == m_lim[1]);
      chk(peri_en == e_p, "R1 peri_en", 32'(peri_en), 32'(e_p));
      chk(slow_en == e_s, "R2 slow_en", 32'(slow_en), 32'(e_s));
      chk(cfg_rdata == word_of(m_fld[0], m_fld[1]), "R3 readback",
          cfg_rdata, word_of(m_fld[0], m_fld[1]));
      if (wk) begin
         for (int i = 0; i < 2; i++) begin
            m_cnt[i] = '0; m_lim[i] = m_fld[i];
         end
      end else begin
         if (m_cnt[0] == m_lim[0]) begin m_cnt[0] = '0; m_lim[0] = m_fld[0]; end
         else m_cnt[0] = m_cnt[0] + 8'd1;
         if (e_p) begin
            if (m_cnt[1] == m_lim[1]) begin m_cnt[1] = '0; m_lim[1] = m_fld[1]; end
            else m_cnt[1] = m_cnt[1] + 8'd1;
         end
      end
      if (we) begin
         m_fld[0] = wd[31:24];
         m_fld[1] = wd[15:8];
      end
      cyc++;
   endtask

   // Program P/S, sync with a sleep-exit event, then measure strobe spacing.
   task automatic measure(input int p, input int s);
      int per_p;
      int per_s;
      int first_p;
      int second_p;
      int first_s;
      int second_s;
      per_p = p + 1;
      per_s = (p + 1) * (s + 1);
      first_p = -1; second_p = -1; first_s = -1; second_s = -1;
      step(1'b1, word_of(8'(p), 8'(s)) | 32'h00AA_0055, 1'b0);
      step(1'b0, 32'hFFFF_FFFF, 1'b1);   // event cycle = offset 0
      // R7: word unchanged by the event
      chk(cfg_rdata == word_of(8'(p), 8'(s)), "R7 kept over wake",
          cfg_rdata, word_of(8'(p), 8'(s)));
      for (int c = 1; c <= 2 * per_s + 1; c++) begin
         step(1'b0, 32'h0, 1'b0);
         if (peri_en) begin
            if (first_p < 0) first_p = c; else if (second_p < 0) second_p = c;
         end
         if (slow_en) begin
            if (first_s < 0) first_s = c; else if (second_s < 0) second_s = c;
         end
      end
      chk(first_p == per_p, "R5 first peri after wake", 32'(first_p), 32'(per_p));
      chk(second_p - first_p == per_p, "R1 peri period", 32'(second_p - first_p), 32'(per_p));
      chk(first_s == per_s, "R5 first slow after wake", 32'(first_s), 32'(per_s));
      chk(second_s - first_s == per_s, "R2 slow period", 32'(second_s - first_s), 32'(per_s));
   endtask

   initial begin
      int t1;
      int t2;
      void'($urandom(32'h5EED_0C1D));
      model_reset();
      // R4: reset state
      repeat (3) @(negedge clk);
      #1;
      chk(cfg_rdata == 32'h0, "R4 reset word", cfg_rdata, 32'h0);
      chk(peri_en && slow_en, "R4 enables in reset", {30'h0, peri_en, slow_en}, 32'h3);
      rst_n = 1'b1;
      repeat (4) step(1'b0, 32'h0, 1'b0);

      // R3: all ones written; reserved bits read zero
      step(1'b1, 32'hFFFF_FFFF, 1'b0);
      step(1'b0, 32'h0, 1'b0);
      chk(cfg_rdata == 32'hFF00_FF00, "R3 field map", cfg_rdata, 32'hFF00_FF00);
      // R8: data without strobe ignored
      step(1'b0, 32'h1234_5678, 1'b0);
      step(1'b0, 32'h0, 1'b0);
      chk(cfg_rdata == 32'hFF00_FF00, "R8 no strobe", cfg_rdata, 32'hFF00_FF00);

      // Directed period measurements, including both extremes
      measure(3, 2);
      measure(0, 0);
      measure(255, 1);
      measure(0, 255);
      measure(7, 0);

      // R6: change P from 9 to 2 mid-count
      step(1'b1, word_of(8'd9, 8'd0), 1'b0);
      step(1'b0, 32'h0, 1'b1);
      t1 = -1; t2 = -1;
      for (int c = 1; c <= 20; c++) begin
         step(c == 4, word_of(8'd2, 8'd0), 1'b0);
         if (peri_en) begin
            if (t1 < 0) t1 = c; else if (t2 < 0) t2 = c;
         end
      end
      chk(t1 == 10, "R6 old period completes", 32'(t1), 32'd10);
      chk(t2 == 13, "R6 new period at wrap", 32'(t2), 32'd13);

      // Random traffic against the model
      for (int k = 0; k < 4000; k++) begin
         bit          we;
         bit          wk;
         logic [31:0] wd;
         we = ($urandom % 40) == 0;
         wk = ($urandom % 120) == 0;
         wd = $urandom;
         if ($urandom % 2) wd = wd & 32'h0300_0300;
         step(we, wd, wk);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule